// File: doc/BRIEF.md
# Paged Register Window Decoder

This block is the address decoder that sits behind the protocol engine of a small serial-bus slave. The slave has an 8-bit register space. The lower half holds volatile registers: a device type word, a revision byte, a two-byte vendor identity and a page-select register. The upper half is a 128-byte window onto a read-only non-volatile array of up to eight pages. The page-select register chooses which page the window shows.

The protocol engine drives single-cycle strobes: `rd_en` reads at `addr`, `wr_en` writes `wdata` at `addr`, and `seq_rd` reads the next address after the last access. Every access, whether a read or a write, sets that next address.

Read data is registered. While a page other than page 0 is selected, every low-half register except the page-select register reads as zero. The array content is computed at elaboration from parameters, so the array synthesizes as a ROM.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the page-select register holds page 0 with the mode flag clear, and `rdata` is 0x00.
- R2: The page-select register at 0x0B stores `wdata[3:0]` on a write. Bits [2:0] are the page and bit 3 is the mode flag. A read returns `{4'b0000, mode, page}`, so bits [7:4] are always zero.
- R3: With page 0 selected, address 0x00 reads 0x51 and address 0x01 reads 0x18, whatever the mode flag holds.
- R4: With page 0 selected, address 0x02 reads `{2'b00, major-1, minor-1, 1'b0}`, with major-1 in bits [5:4] and minor-1 in bits [3:1]. The defaults are major 2 and minor 3, so the byte is 0x14.
- R5: With page 0 selected, address 0x03 reads the vendor bank and address 0x04 reads the vendor id. Each byte is its 7-bit value with bit 7 set so that the byte holds an odd number of ones. The defaults are bank 0x03 and id 0x1A, so the bytes are 0x83 and 0x1A.
- R6: While the selected page is non-zero, every address from 0x00 to 0x7F except 0x0B reads 0x00.
- R7: An address A in 0x80..0xFF reads array byte i = page*128 + (A & 0x7F). With default parameters, byte i = (i*37 + (i/128)*101 + 0x5A) mod 256.
- R8: A write to any address other than 0x0B changes neither the page-select register nor the array contents.
- R9: `rdata` takes the value of a read in the clock cycle after its strobe, and holds it until the next read strobe.
- R10: Every access sets a next address. After an access to A in 0x80..0xFF it is `{1, (A+1) & 0x7F}`, which wraps within the same window page. After an access to A below 0x80 it is A+1. A `seq_rd` strobe reads at that next address and advances it by the same rule.
- R11: With page 0 selected, low-half addresses that hold no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe at `addr` |
| seq_rd | input | 1 | Read strobe at the internal next address |
| wr_en | input | 1 | Write strobe at `addr` |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The assertions assume that the protocol engine asserts at most one of `rd_en` and `seq_rd` in a cycle. They also assume that when a read and a write arrive together, the read returns the value from before the write. The stimulus raises each strobe for exactly one cycle, never drives `rd_en` together with `seq_rd`, and uses a combined read and write only on the page register, where both the checker and the reference model expect the old value. Page changes are always separate writes, followed by full window sweeps and by reads of the gated low half.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int BYTE_W      = 8;
   localparam int ADDR_W      = 8;
   localparam int OFF_W       = 7;
   localparam int WIN_BYTES   = 128;
   localparam int PSEL_W      = 3;

   localparam logic [ADDR_W-1:0] A_TYPE_HI = 8'h00;
   localparam logic [ADDR_W-1:0] A_TYPE_LO = 8'h01;
   localparam logic [ADDR_W-1:0] A_REV     = 8'h02;
   localparam logic [ADDR_W-1:0] A_VBANK   = 8'h03;
   localparam logic [ADDR_W-1:0] A_VID     = 8'h04;
   localparam logic [ADDR_W-1:0] A_PSEL    = 8'h0B;

   typedef struct packed {
      logic              mode;
      logic [PSEL_W-1:0] page;
   } psel_t;

   function automatic logic [BYTE_W-1:0] odd_par_byte(input logic [6:0] v);
      return {~(^v), v};
   endfunction

   function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
      if (a[ADDR_W-1])
         return {1'b1, a[OFF_W-1:0] + 7'd1};
      else
         return a + 8'd1;
   endfunction
endpackage

// File: rtl/regwin_page_reg.sv
module regwin_page_reg
   import regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        wnib,
   output psel_t             psel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         psel <= '0;
      else if (wr_en && addr == A_PSEL)
         psel <= psel_t'(wnib);
   end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
   import regwin_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= next_addr(load_addr);
      else if (step)
         ptr <= next_addr(ptr);
   end
endmodule

// File: rtl/regwin_ident.sv
module regwin_ident
   import regwin_pkg::*;
#(
   parameter logic [15:0] DEV_TYPE    = 16'h5118,
   parameter int          REV_MAJOR   = 2,
   parameter int          REV_MINOR   = 3,
   parameter logic [6:0]  VENDOR_BANK = 7'h03,
   parameter logic [6:0]  VENDOR_ID   = 7'h1A
)(
   input  logic [ADDR_W-1:0] addr,
   input  psel_t             psel,
   output logic [BYTE_W-1:0] data
);
   localparam logic [1:0] REV_MAJ_F = 2'(REV_MAJOR - 1);
   localparam logic [2:0] REV_MIN_F = 3'(REV_MINOR - 1);
   localparam logic [BYTE_W-1:0] REV_BYTE = {2'b00, REV_MAJ_F, REV_MIN_F, 1'b0};

   logic gated;
   assign gated = (psel.page != '0);

   always_comb begin
      data = '0;
      if (addr == A_PSEL) begin
         data = {4'b0000, psel};
      end else if (!gated) begin
         case (addr)
            A_TYPE_HI: data = DEV_TYPE[15:8];
            A_TYPE_LO: data = DEV_TYPE[7:0];
            A_REV:     data = REV_BYTE;
            A_VBANK:   data = odd_par_byte(VENDOR_BANK);
            A_VID:     data = odd_par_byte(VENDOR_ID);
            default:   data = '0;
         endcase
      end
   end
endmodule

// File: rtl/regwin_nvm_rom.sv
module regwin_nvm_rom
   import regwin_pkg::*;
#(
   parameter int PAGE_COUNT   = 8,
   parameter int ROM_MUL      = 37,
   parameter int ROM_PAGE_ADD = 101,
   parameter int ROM_BASE     = 90
)(
   input  logic [PSEL_W-1:0] page,
   input  logic [OFF_W-1:0]  off,
   output logic [BYTE_W-1:0] data
);
   localparam int DEPTH = PAGE_COUNT * WIN_BYTES;
   localparam int IDX_W = $clog2(DEPTH);

   logic [BYTE_W-1:0]        mem [DEPTH];
   logic [PSEL_W+OFF_W-1:0]  idx_full;

   assign idx_full = {page, off};

   for (genvar g = 0; g < DEPTH; g++) begin : g_fill
      assign mem[g] = 8'((g * ROM_MUL + (g / WIN_BYTES) * ROM_PAGE_ADD + ROM_BASE) % 256);
   end

   if (PAGE_COUNT == (1 << PSEL_W)) begin : g_full
      assign data = mem[idx_full];
   end else begin : g_partial
      logic in_range;
      assign in_range = ({1'b0, page} < 4'(PAGE_COUNT));
      assign data = in_range ? mem[idx_full[IDX_W-1:0]] : '0;
   end
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
   import regwin_pkg::*;
#(
   parameter int          PAGE_COUNT   = 8,
   parameter logic [15:0] DEV_TYPE     = 16'h5118,
   parameter int          REV_MAJOR    = 2,
   parameter int          REV_MINOR    = 3,
   parameter logic [6:0]  VENDOR_BANK  = 7'h03,
   parameter logic [6:0]  VENDOR_ID    = 7'h1A,
   parameter int          ROM_MUL      = 37,
   parameter int          ROM_PAGE_ADD = 101,
   parameter int          ROM_BASE     = 90
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_en,
   input  logic        seq_rd,
   input  logic        wr_en,
   input  logic [7:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata
);
   if (PAGE_COUNT < 1 || PAGE_COUNT > (1 << PSEL_W)) begin : g_bad_pages
      $error("PAGE_COUNT must lie in 1..8");
   end
   if (REV_MAJOR < 1 || REV_MAJOR > 4) begin : g_bad_major
      $error("REV_MAJOR must lie in 1..4");
   end
   if (REV_MINOR < 1 || REV_MINOR > 8) begin : g_bad_minor
      $error("REV_MINOR must lie in 1..8");
   end
   if (VENDOR_ID == 7'h00 || VENDOR_ID == 7'h7F) begin : g_bad_vid
      $error("VENDOR_ID 0x00 and 0x7F are reserved");
   end

   psel_t              psel_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic [ADDR_W-1:0]  rd_addr;
   logic [BYTE_W-1:0]  low_byte;
   logic [BYTE_W-1:0]  rom_byte;
   logic               rd_any;

   assign rd_any  = rd_en | seq_rd;
   assign rd_addr = rd_en ? addr : ptr_q;

   regwin_page_reg u_psel (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wnib  (wdata[3:0]),
      .psel  (psel_q)
   );

   regwin_ptr u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_en | wr_en),
      .load_addr (addr),
      .step      (seq_rd),
      .ptr       (ptr_q)
   );

   regwin_ident #(
      .DEV_TYPE    (DEV_TYPE),
      .REV_MAJOR   (REV_MAJOR),
      .REV_MINOR   (REV_MINOR),
      .VENDOR_BANK (VENDOR_BANK),
      .VENDOR_ID   (VENDOR_ID)
   ) u_ident (
      .addr (rd_addr),
      .psel (psel_q),
      .data (low_byte)
   );

   regwin_nvm_rom #(
      .PAGE_COUNT   (PAGE_COUNT),
      .ROM_MUL      (ROM_MUL),
      .ROM_PAGE_ADD (ROM_PAGE_ADD),
      .ROM_BASE     (ROM_BASE)
   ) u_rom (
      .page (psel_q.page),
      .off  (rd_addr[OFF_W-1:0]),
      .data (rom_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_any)
         rdata <= rd_addr[ADDR_W-1] ? rom_byte : low_byte;
   end
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_en,
   input logic       seq_rd,
   input logic       wr_en,
   input logic [7:0] addr,
   input logic [7:0] wdata,
   input logic [7:0] rdata,
   input logic [3:0] psel,
   input logic [7:0] ptr
);
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en && !seq_rd) |=> $stable(rdata)); // R9

   AST_PSEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == 8'h0B) |=> (rdata[7:4] == 4'h0)); // R2

   AST_PSEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'h0B) |=> ({4'h0, psel} == $past(wdata & 8'h0F))); // R2

   AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr != 8'h0B) |=> $stable(psel)); // R8

   AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && psel[2:0] != 3'd0 && !addr[7] && addr != 8'h0B) |=> (rdata == 8'h00)); // R6

   AST_TYPE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && psel[2:0] == 3'd0 && addr == 8'h00) |=> (rdata == 8'h51)); // R3

   AST_VENDOR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && psel[2:0] == 3'd0 && (addr == 8'h03 || addr == 8'h04))
      |=> ($countones(rdata) % 2 == 1)); // R5

   AST_WINDOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && addr == 8'hFF) |=> (ptr == 8'h80)); // R10

   AST_SEQ_STAYS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_rd && !rd_en && !wr_en && ptr[7]) |=> ptr[7]); // R10
endmodule

bind regwin_decoder regwin_checker u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd_en  (rd_en),
   .seq_rd (seq_rd),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .rdata  (rdata),
   .psel   (psel_q),
   .ptr    (ptr_q)
);

// File: tb/test_regwin_decoder.sv
module test_regwin_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0;
   logic       seq_rd = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";
   bit    done     = 1'b0;

   always #4 clk = ~clk;

   regwin_decoder i_regwin_decoder (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .seq_rd (seq_rd),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .rdata  (rdata)
   );

   // reference model
   int   m_page = 0;
   int   m_mode = 0;
   int   m_ptr  = 0;
   int   m_exp  = 0;

   function automatic int rom_exp(int i);
      return (i * 37 + (i / 128) * 101 + 90) % 256;
   endfunction

   function automatic int par_byte(int v);
      int ones = 0;
      for (int b = 0; b < 7; b++) ones += (v >> b) & 1;
      return (ones % 2 == 0) ? (v | 128) : v;
   endfunction

   function automatic int model_read(int a);
      if (a >= 128) return rom_exp(m_page * 128 + (a % 128));
      if (a == 11)  return m_mode * 8 + m_page;
      if (m_page != 0) return 0;
      case (a)
         0: return 'h51;
         1: return 'h18;
         2: return 16 + 4;
         3: return par_byte('h03);
         4: return par_byte('h1A);
         default: return 0;
      endcase
   endfunction

   function automatic int model_next(int a);
      if (a >= 128) return 128 + ((a + 1) % 128);
      return (a + 1) % 256;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_page = 0; m_mode = 0; m_ptr = 0; m_exp = 0;
      end else begin
         int a;
         a = rd_en ? int'(addr) : m_ptr;
         if (rd_en || seq_rd) m_exp = model_read(a);
         if (rd_en || wr_en) m_ptr = model_next(int'(addr));
         else if (seq_rd)    m_ptr = model_next(m_ptr);
         if (wr_en && addr == 8'h0B) begin
            m_page = int'(wdata[2:0]);
            m_mode = int'(wdata[3]);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (int'(rdata) != m_exp) begin
            n_fails++;
            $display("FAIL %s: rdata=0x%02h expected 0x%02h at %0t", cur_req, rdata, m_exp[7:0], $time);
         end
      end
   end

   task automatic drive(input logic r, input logic s, input logic w,
                        input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      #1;
      rd_en = r; seq_rd = s; wr_en = w; addr = a; wdata = d;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic rd(input logic [7:0] a);
      drive(1'b1, 1'b0, 1'b0, a, 8'h00);
   endtask

   task automatic sq();
      drive(1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      drive(1'b0, 1'b0, 1'b1, a, d);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset state of rdata and the page register
      cur_req = "R1";
      idle(2);
      rd(8'h0B); idle(1);
      // R3 type bytes
      cur_req = "R3";
      rd(8'h00); rd(8'h01); idle(1);
      // R4 revision
      cur_req = "R4";
      rd(8'h02); idle(1);
      // R5 vendor bytes with odd parity
      cur_req = "R5";
      rd(8'h03); rd(8'h04); idle(1);
      // R11 unlisted low addresses
      cur_req = "R11";
      for (int a = 5; a < 128; a++) if (a != 11) rd(8'(a));
      idle(1);
      // R7 / R10: every page, first byte by address, the rest by sequential reads
      for (int p = 0; p < 8; p++) begin
         cur_req = "R2";
         wr(8'h0B, 8'(p));
         cur_req = "R7";
         rd(8'h80);
         cur_req = "R10";
         for (int k = 0; k < 128; k++) sq();
         cur_req = "R7";
         rd(8'hC5); rd(8'hFF);
         idle(1);
      end
      // R6: gated low half on a non-zero page
      cur_req = "R2";
      wr(8'h0B, 8'h03);
      cur_req = "R6";
      for (int a = 0; a < 128; a++) rd(8'(a));
      idle(1);
      // R2: upper nibble of the write is dropped, mode bit kept
      cur_req = "R2";
      wr(8'h0B, 8'hF5); rd(8'h0B); idle(1);
      wr(8'h0B, 8'h08); rd(8'h0B);
      cur_req = "R3";
      rd(8'h00); rd(8'h01); idle(1);
      // R8: writes elsewhere are ignored
      cur_req = "R8";
      wr(8'h0B, 8'h02);
      wr(8'h90, 8'h00); wr(8'h00, 8'h07); wr(8'h20, 8'h05); wr(8'hFF, 8'h01);
      rd(8'h0B); rd(8'h90); rd(8'hFF); idle(1);
      // R10: wrap at the top of the window, and step out of the low half
      cur_req = "R10";
      rd(8'hFE); sq(); sq(); sq(); idle(1);
      wr(8'h0B, 8'h00);
      rd(8'h7E); sq(); sq(); sq(); idle(1);
      wr(8'h0B, 8'h00); sq(); sq(); idle(1);
      wr(8'hFF, 8'h00); sq(); idle(1);
      // R9: hold across idle cycles and a read concurrent with a page write
      cur_req = "R9";
      rd(8'h01); idle(5);
      drive(1'b1, 1'b0, 1'b1, 8'h0B, 8'h06); idle(2);
      rd(8'h0B); idle(3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end
endmodule